// File: doc/BRIEF.md
# Accumulator Extract Unit

This unit takes a 64-bit signed accumulator, presented as an upper and a lower 32-bit word, and shifts it arithmetically right by a 5-bit amount. It then forms one 32-bit word in one of four modes: a plain truncation of the shifted value, a rounded value, a rounded value that saturates to the signed 32-bit range, or a value clamped to the signed 16-bit range and sign-extended. With each result it gives a one-bit overflow request that tells the surrounding control logic to set its extract-overflow status bit.

Rounding adds half of the last discarded weight before the final shift. The unit does this by shifting one place less than asked, widening to 65 bits with the accumulator sign as the extra top bit, adding one and then dropping the lowest bit. A shift of zero is handled by moving the accumulator one place left instead. Each request is accepted with a valid strobe and its result comes out of a register on the next clock edge.

Top module: `acc_extract`

## Requirements
- R1: The shift amount `shamt` is 5 bits wide. Every value from 0 to 31 is honoured, and 0 leaves the accumulator unshifted in every mode.
- R2: In truncate mode (`mode` = 2'b00) the result is the low 32 bits of the accumulator shifted arithmetically right by `shamt`.
- R3: In truncate mode the overflow request is 1 exactly when the shifted value lies outside the signed 32-bit range.
- R4: In round mode (`mode` = 2'b01) the result is the low 32 bits of floor((acc + 2^(shamt-1)) / 2^shamt). For `shamt` = 0 it is floor(acc). The sum is formed without loss, so a carry out of 64 bits is kept.
- R5: In both rounding modes the overflow request is 1 exactly when that rounded value lies outside the signed 32-bit range.
- R6: In round-saturate mode (`mode` = 2'b10), an overflowing rounded value is replaced by 32'h7FFFFFFF when it is positive and by 32'h80000000 when it is negative. A value that does not overflow passes through unchanged.
- R7: In halfword mode (`mode` = 2'b11) the arithmetically shifted value is clamped to [-32768, 32767] and sign-extended to 32 bits, so the clamps give 32'h00007FFF and 32'hFFFF8000. The overflow request is 1 exactly when a clamp was applied.
- R8: A request taken while `in_valid` is high at a clock edge appears on `result` and `ovf_req`, with `out_valid` high, right after that edge. `ovf_req` is never high while `out_valid` is low.
- R9: After an edge where `in_valid` is low, `out_valid` and `ovf_req` are 0 and `result` keeps its previous value, whatever the other inputs carry.
- R10: Synchronous active-high reset clears `out_valid`, `ovf_req` and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| acc_hi | input | 32 | Upper half of the accumulator |
| acc_lo | input | 32 | Lower half of the accumulator |
| shamt | input | 5 | Arithmetic right-shift amount |
| mode | input | 2 | 00 truncate, 01 round, 10 round-saturate, 11 halfword clamp |
| out_valid | output | 1 | Result word and flag are valid |
| result | output | 32 | Extracted word |
| ovf_req | output | 1 | Request to set the extract-overflow status bit |

## Verification
The whole datapath is combinational up to a single output register, so every result, flag and valid bit is due exactly one rising edge after the edge that takes the request. The bench drives each request on a falling edge and holds it across one rising edge. It compares all three outputs on the following falling edge, half a period after the register updates. It then drops the strobe and checks on later falling edges that the valid bit and the flag have cleared and the word has held. The expected values come from a wide signed model in the bench that applies the rounding and clamping arithmetic directly.

// File: rtl/acx_pkg.sv
package acx_pkg;

    localparam int ACX_ACC_W  = 64;
    localparam int ACX_RES_W  = 32;
    localparam int ACX_SH_W   = 5;
    localparam int ACX_HALF_W = 16;

    typedef enum logic [1:0] {
        XM_TRUNC = 2'b00,
        XM_ROUND = 2'b01,
        XM_RSAT  = 2'b10,
        XM_HSAT  = 2'b11
    } xmode_e;

    function automatic logic xmode_rounds(input xmode_e m);
        return (m == XM_ROUND) || (m == XM_RSAT);
    endfunction

endpackage

// File: rtl/acx_shift.sv
module acx_shift #(
    parameter int ACC_W = acx_pkg::ACX_ACC_W,
    parameter int SH_W  = acx_pkg::ACX_SH_W
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [SH_W-1:0]  sh,
    output logic [ACC_W-1:0] shifted,
    output logic [ACC_W:0]   pre
);
    // Plain arithmetic shift for truncate and halfword modes.
    assign shifted = ACC_W'($signed(acc) >>> sh);

    // Rounding intermediate: shift one place less, sign kept as an extra top bit.
    always_comb begin
        if (sh == '0) begin
            pre = {acc[ACC_W-1], acc[ACC_W-2:0], 1'b0};
        end else begin
            pre = {acc[ACC_W-1], ACC_W'($signed(acc) >>> (sh - 1'b1))};
        end
    end
endmodule

// File: rtl/acx_round.sv
module acx_round #(
    parameter int ACC_W = acx_pkg::ACX_ACC_W,
    parameter int RES_W = acx_pkg::ACX_RES_W
) (
    input  logic [ACC_W:0]   pre,
    input  logic             sat_en,
    output logic [RES_W-1:0] word,
    output logic             ovf
);
    localparam logic [RES_W-1:0] POS_RAIL = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] NEG_RAIL = {1'b1, {(RES_W-1){1'b0}}};

    // Adding one then dropping bit 0 equals adding bit 0 to the upper bits.
    logic [ACC_W-1:0]     halved;
    logic [ACC_W-RES_W:0] upper;

    assign halved = pre[ACC_W:1] + {{(ACC_W-1){1'b0}}, pre[0]};
    assign upper  = halved[ACC_W-1:RES_W-1];
    assign ovf    = (|upper) && !(&upper);

    always_comb begin
        if (sat_en && ovf) begin
            word = halved[ACC_W-1] ? NEG_RAIL : POS_RAIL;
        end else begin
            word = halved[RES_W-1:0];
        end
    end
endmodule

// File: rtl/acx_clamp.sv
module acx_clamp #(
    parameter int ACC_W  = acx_pkg::ACX_ACC_W,
    parameter int RES_W  = acx_pkg::ACX_RES_W,
    parameter int HALF_W = acx_pkg::ACX_HALF_W
) (
    input  logic [ACC_W-1:0] shifted,
    output logic [RES_W-1:0] word,
    output logic             ovf
);
    localparam int EXT_W = RES_W - HALF_W;
    localparam logic [RES_W-1:0] HMAX = {{(EXT_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
    localparam logic [RES_W-1:0] HMIN = {{(EXT_W+1){1'b1}}, {(HALF_W-1){1'b0}}};

    logic [ACC_W-HALF_W:0] hi;
    logic                  neg;

    assign hi  = shifted[ACC_W-1:HALF_W-1];
    assign neg = shifted[ACC_W-1];

    always_comb begin
        if (!neg && (|hi)) begin
            word = HMAX;
            ovf  = 1'b1;
        end else if (neg && !(&hi)) begin
            word = HMIN;
            ovf  = 1'b1;
        end else begin
            word = {{EXT_W{shifted[HALF_W-1]}}, shifted[HALF_W-1:0]};
            ovf  = 1'b0;
        end
    end
endmodule

// File: rtl/acc_extract.sv
module acc_extract
    import acx_pkg::*;
#(
    parameter int ACC_W  = ACX_ACC_W,
    parameter int RES_W  = ACX_RES_W,
    parameter int SH_W   = ACX_SH_W,
    parameter int HALF_W = ACX_HALF_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [ACC_W/2-1:0]   acc_hi,
    input  logic [ACC_W/2-1:0]   acc_lo,
    input  logic [SH_W-1:0]      shamt,
    input  logic [1:0]           mode,
    output logic                 out_valid,
    output logic [RES_W-1:0]     result,
    output logic                 ovf_req
);
    localparam logic [RES_W-1:0] POS_RAIL = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] NEG_RAIL = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        logic             vld;
        logic             ovf;
        logic [RES_W-1:0] word;
    } xout_t;

    xmode_e           mode_e;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] shifted;
    logic [ACC_W:0]   pre;
    logic [RES_W-1:0] rnd_word, hs_word, tr_word;
    logic             rnd_ovf, hs_ovf, tr_ovf;
    logic [ACC_W-RES_W:0] tr_upper;
    xout_t            nxt, cur;
    xmode_e           mode_q;

    assign mode_e = xmode_e'(mode);
    assign acc    = {acc_hi, acc_lo};

    acx_shift #(.ACC_W(ACC_W), .SH_W(SH_W)) u_shift (
        .acc     (acc),
        .sh      (shamt),
        .shifted (shifted),
        .pre     (pre)
    );

    acx_round #(.ACC_W(ACC_W), .RES_W(RES_W)) u_round (
        .pre    (pre),
        .sat_en (mode_e == XM_RSAT),
        .word   (rnd_word),
        .ovf    (rnd_ovf)
    );

    acx_clamp #(.ACC_W(ACC_W), .RES_W(RES_W), .HALF_W(HALF_W)) u_clamp (
        .shifted (shifted),
        .word    (hs_word),
        .ovf     (hs_ovf)
    );

    // Truncate path: low word, flagged when the value leaves the signed range.
    assign tr_word  = shifted[RES_W-1:0];
    assign tr_upper = shifted[ACC_W-1:RES_W-1];
    assign tr_ovf   = (|tr_upper) && !(&tr_upper);

    always_comb begin
        nxt.vld = in_valid;
        if (xmode_rounds(mode_e)) begin
            nxt.word = rnd_word;
            nxt.ovf  = rnd_ovf;
        end else if (mode_e == XM_HSAT) begin
            nxt.word = hs_word;
            nxt.ovf  = hs_ovf;
        end else begin
            nxt.word = tr_word;
            nxt.ovf  = tr_ovf;
        end
        nxt.ovf = nxt.ovf && in_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            mode_q <= XM_TRUNC;
        end else begin
            cur.vld <= nxt.vld;
            cur.ovf <= nxt.ovf;
            if (in_valid) begin
                cur.word <= nxt.word;
                mode_q   <= mode_e;
            end
        end
    end

    assign out_valid = cur.vld;
    assign result    = cur.word;
    assign ovf_req   = cur.ovf;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R8
    AST_FLAG_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        ovf_req |-> out_valid); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !ovf_req && $stable(result))); // R9
    AST_RSAT_RAIL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ovf_req && mode_q == XM_RSAT) |->
        (result == POS_RAIL || result == NEG_RAIL)); // R6
    AST_HALF_RANGE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode_q == XM_HSAT) |->
        ((&result[RES_W-1:HALF_W-1]) || !(|result[RES_W-1:HALF_W-1]))); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !ovf_req && result == '0)); // R10
endmodule

// File: tb/tb_acc_extract.sv
module tb_acc_extract;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] acc_hi, acc_lo;
    logic [4:0]  shamt;
    logic [1:0]  mode;
    logic        out_valid;
    logic [31:0] result;
    logic        ovf_req;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    acc_extract dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .shamt(shamt), .mode(mode),
        .out_valid(out_valid), .result(result), .ovf_req(ovf_req)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Wide signed model of the four modes.
    task automatic model(input logic [63:0] a, input logic [4:0] s, input logic [1:0] md,
                         output logic [31:0] w, output logic f);
        logic signed [65:0] x, r, half;
        logic signed [65:0] p32, n32, p16, n16;
        x    = $signed({a[63], a[63], a});
        p32  = 66'sd2147483647;
        n32  = -66'sd2147483648;
        p16  = 66'sd32767;
        n16  = -66'sd32768;
        half = (s == 0) ? 66'sd0 : (66'sd1 <<< (s - 1));
        if (md == 2'b00 || md == 2'b11) r = x >>> s;
        else r = (x + half) >>> s;
        w = r[31:0];
        if (md == 2'b11) begin
            f = (r > p16) || (r < n16);
            if (r > p16) w = 32'h0000_7FFF;
            else if (r < n16) w = 32'hFFFF_8000;
        end else begin
            f = (r > p32) || (r < n32);
            if (md == 2'b10 && f) w = r[65] ? 32'h8000_0000 : 32'h7FFF_FFFF;
        end
    endtask

    task automatic apply(input logic [63:0] a, input logic [4:0] s, input logic [1:0] md,
                         input string tag);
        logic [31:0] ew;
        logic        ef;
        model(a, s, md, ew, ef);
        @(negedge clk);
        in_valid = 1'b1;
        {acc_hi, acc_lo} = a;
        shamt = s;
        mode  = md;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, {tag, " R8 valid"}, 64'(out_valid), 64'd1);
        check(result === ew, {tag, " result"}, 64'(result), 64'(ew));
        check(ovf_req === ef, {tag, " flag"}, 64'(ovf_req), 64'(ef));
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; acc_hi = '0; acc_lo = '0; shamt = '0; mode = '0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && ovf_req === 1'b0, "R10 reset flags",
              64'({out_valid, ovf_req}), 64'd0);
        check(result === 32'd0, "R10 reset result", 64'(result), 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_trunc;
        apply(64'h0000_0000_1234_5678, 5'd0,  2'b00, "R2 trunc s0");
        apply(64'hFFFF_FFFF_8000_0000, 5'd4,  2'b00, "R2 trunc neg");
        apply(64'h0000_0001_0000_0000, 5'd0,  2'b00, "R3 trunc ovf pos");
        apply(64'h0000_0001_0000_0000, 5'd1,  2'b00, "R3 trunc edge");
        apply(64'hFFFF_FFFF_7FFF_FFFF, 5'd0,  2'b00, "R3 trunc ovf neg");
        apply(64'h7FFF_FFFF_FFFF_FFFF, 5'd31, 2'b00, "R1 trunc s31");
    endtask

    task automatic t_round;
        apply(64'h0000_0000_0000_0003, 5'd1,  2'b01, "R4 round up");
        apply(64'hFFFF_FFFF_FFFF_FFFD, 5'd1,  2'b01, "R4 round neg");
        apply(64'h0000_0000_DEAD_BEEF, 5'd0,  2'b01, "R1 round s0");
        apply(64'h0000_0000_FFFF_FFFF, 5'd1,  2'b01, "R5 round carry ovf");
        apply(64'h7FFF_FFFF_FFFF_FFFF, 5'd1,  2'b01, "R5 round wide carry");
        apply(64'h0000_0000_7FFF_FFFF, 5'd31, 2'b01, "R4 round s31");
    endtask

    task automatic t_rsat;
        apply(64'h7FFF_FFFF_FFFF_FFFF, 5'd0,  2'b10, "R6 rsat pos");
        apply(64'h8000_0000_0000_0000, 5'd0,  2'b10, "R6 rsat neg");
        apply(64'h0000_0000_FFFF_FFFE, 5'd1,  2'b10, "R6 rsat just max");
        apply(64'h0000_0000_FFFF_FFFF, 5'd1,  2'b10, "R6 rsat round over");
        apply(64'hFFFF_FFFF_0000_0000, 5'd1,  2'b10, "R6 rsat just min");
    endtask

    task automatic t_half;
        apply(64'h0000_0000_0000_7FFF, 5'd0,  2'b11, "R7 half max");
        apply(64'h0000_0000_0000_8000, 5'd0,  2'b11, "R7 half clamp pos");
        apply(64'hFFFF_FFFF_FFFF_8000, 5'd0,  2'b11, "R7 half min");
        apply(64'hFFFF_FFFF_FFFF_7FFF, 5'd0,  2'b11, "R7 half clamp neg");
        apply(64'h0000_0000_0001_0000, 5'd2,  2'b11, "R7 half shifted");
        apply(64'h8000_0000_0000_0000, 5'd31, 2'b11, "R7 half big neg");
    endtask

    task automatic t_idle;
        logic [31:0] held;
        apply(64'h0000_0001_0000_0000, 5'd0, 2'b00, "R9 setup");
        held = result;
        acc_hi = 32'hAAAA_5555; acc_lo = 32'h1234_4321; shamt = 5'd7; mode = 2'b11;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R9 idle valid", 64'(out_valid), 64'd0);
            check(ovf_req === 1'b0, "R9 idle flag", 64'(ovf_req), 64'd0);
            check(result === held, "R9 idle hold", 64'(result), 64'(held));
        end
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a;
            a = {$urandom, $urandom};
            if (i % 3 == 0) a = {{32{a[40]}}, a[31:0]};
            if (i % 5 == 0) a = {{48{a[20]}}, a[15:0]};
            apply(a, 5'(i % 32), 2'(i / 32), "R5 sweep");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset;
        t_trunc;
        t_round;
        t_rsat;
        t_half;
        t_idle;
        t_sweep;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule